// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of a synchronous DRAM read or write burst. A start strobe carries the first column. From then on the block steps through the burst in the programmed order, one beat per clock. It raises a beat-valid flag while a burst is running and a last-beat flag on the final beat of a bounded burst.

The burst length and ordering inputs are sampled only on the cycle that carries the start strobe. Each of the following can happen on any cycle, with no minimum gap:
- a terminate strobe stops the burst at once;
- a fresh start discards the running burst and begins the new one.

Command decoding, bank and row selection, the data path and read-latency staging are left to neighbouring logic.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, and on every cycle that beat-valid is low, beat-valid and last-beat read 0 and the column output reads 0.
- R2: A start strobe sampled at a rising edge makes beat 0 appear on the following cycle, with beat-valid high and the column equal to the start column.
- R3: The burst-length field selects the number of beats: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives a full page. The reserved codes 3'b100 to 3'b110 give 1 beat.
- R4: Last-beat is high exactly on beat BL-1 of a bounded burst. Beat-valid falls on the next cycle unless a new start arrived.
- R5: With ordering bit 0 (sequential), each beat adds 1 to the low log2(BL) column bits and wraps within the aligned block. The upper column bits never change during the burst.
- R6: With ordering bit 1 (interleave), beat n's column is the start column XOR n, applied to the low log2(BL) bits only.
- R7: A sequential full-page burst covers 256 columns. It wraps from 255 to 0, runs until it is terminated or restarted, and never raises last-beat.
- R8: Interleave combined with the full-page code behaves as an 8-beat interleave burst.
- R9: A terminate strobe makes beat-valid low from the next cycle. A terminate strobe while the block is idle has no visible effect.
- R10: A start strobe replaces a running burst immediately and wins over a terminate strobe in the same cycle. Changes to the length or ordering inputs between start strobes do not affect the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startStb | input | 1 | Begin a burst this cycle |
| startCol | input | COL_W | First column of the burst |
| termStb | input | 1 | Stop the running burst |
| lenSel | input | 3 | Burst-length code, sampled with startStb |
| intlvSel | input | 1 | 0 = sequential, 1 = interleave, sampled with startStb |
| colOut | output | COL_W | Column address of the current beat |
| beatValid | output | 1 | A burst beat is present this cycle |
| lastBeat | output | 1 | Current beat is the final one of a bounded burst |

## Verification
The hardest state to reach from the ports is a full-page burst running long enough to wrap past column 255 and then being cut off. It is just as hard to reach a restart landing on the final beat of a bounded burst, where last-beat and a new start coincide. Directed runs cover these cases:
- a full-page burst held for more than 256 cycles, then terminated;
- a start raised together with a terminate;
- mode inputs changed in the middle of a burst.

A long stretch of seeded random starts and terminates then lands restarts on every beat position across all length codes and both orderings. A bench reference model computes the expected column from the start column, the beat index and the latched mode.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

  // Burst-length codes; any other value is treated as one beat.
  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } lenCode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;   // capture start column
    logic step;   // advance to next beat
    logic clear;  // burst over, park column at zero
    logic intlv;  // latched ordering of running burst
  } colStrobe_t;

endpackage

// File: rtl/sdram_colgen_ctrl.sv
module sdram_colgen_ctrl
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W = 8  // must be at least 3 so that 8-beat bursts fit
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic             termStb,
  input  logic [2:0]       lenSel,
  input  logic             intlvSel,
  output colStrobe_t       strb,
  output logic [COL_W-1:0] stepMask,
  output logic [COL_W-1:0] beatNext,
  output logic             beatValid,
  output logic             lastBeat
);

  localparam logic [COL_W-1:0] PAGE_MASK = {COL_W{1'b1}};
  localparam logic [COL_W-1:0] OCT_MASK  = COL_W'(7);

  logic             active;
  logic [COL_W-1:0] beatCnt;
  logic [COL_W-1:0] maskQ;
  logic             intlvQ;
  logic             fullPageQ;

  // Beat-index mask equals BL-1; a full page spans every column bit.
  function automatic logic [COL_W-1:0] lenToMask(input logic [2:0] code,
                                                 input logic il);
    case (code)
      LEN_2:    return COL_W'(1);
      LEN_4:    return COL_W'(3);
      LEN_8:    return OCT_MASK;
      LEN_PAGE: return il ? OCT_MASK : PAGE_MASK;
      default:  return '0;
    endcase
  endfunction

  assign lastBeat  = active && !fullPageQ && (beatCnt == maskQ);
  assign beatValid = active;
  assign stepMask  = maskQ;
  assign beatNext  = beatCnt + COL_W'(1);

  always_comb begin
    strb.load  = startStb;
    strb.clear = !startStb && (termStb || lastBeat);
    strb.step  = !startStb && !termStb && active && !lastBeat;
    strb.intlv = intlvQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      beatCnt   <= '0;
      maskQ     <= '0;
      intlvQ    <= 1'b0;
      fullPageQ <= 1'b0;
    end else if (startStb) begin
      active    <= 1'b1;
      beatCnt   <= '0;
      maskQ     <= lenToMask(lenSel, intlvSel);
      intlvQ    <= intlvSel;
      fullPageQ <= (lenSel == LEN_PAGE) && !intlvSel;
    end else if (termStb) begin
      active    <= 1'b0;
    end else if (active) begin
      if (lastBeat) active <= 1'b0;
      else          beatCnt <= beatNext;
    end
  end

  // The beat index of a bounded burst stays inside its block.
  AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    active && !fullPageQ |-> (beatCnt & ~maskQ) == '0);  // R3

  // A full-page burst never flags a last beat.
  AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rstN)
    fullPageQ && active |-> !lastBeat);  // R7

  // At most one datapath action per cycle.
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.load, strb.step, strb.clear}) <= 1);  // R10

endmodule

// File: rtl/sdram_colgen_dp.sv
module sdram_colgen_dp
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  colStrobe_t       strb,
  input  logic [COL_W-1:0] stepMask,
  input  logic [COL_W-1:0] beatNext,
  input  logic [COL_W-1:0] startCol,
  output logic [COL_W-1:0] colOut
);

  logic [COL_W-1:0] colQ;
  logic [COL_W-1:0] baseQ;
  logic [COL_W-1:0] colInc;
  logic [COL_W-1:0] seqNext;
  logic [COL_W-1:0] intlvNext;

  assign colInc    = colQ + COL_W'(1);
  assign intlvNext = baseQ ^ (beatNext & stepMask);

  // Sequential wrap: masked bits take the incremented value, the rest hold.
  for (genvar i = 0; i < COL_W; i++) begin : g_seqBit
    assign seqNext[i] = stepMask[i] ? colInc[i] : colQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colQ  <= '0;
      baseQ <= '0;
    end else if (strb.load) begin
      colQ  <= startCol;
      baseQ <= startCol;
    end else if (strb.clear) begin
      colQ  <= '0;
    end else if (strb.step) begin
      colQ  <= strb.intlv ? intlvNext : seqNext;
    end
  end

  assign colOut = colQ;

  AST_LOAD_COL: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> colQ == $past(startCol));  // R2

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> ((colQ ^ $past(colQ)) & ~$past(stepMask)) == '0);  // R5

  AST_INTLV_XOR: assert property (@(posedge clk) disable iff (!rstN)
    strb.step && strb.intlv |=> (colQ ^ baseQ) == $past(beatNext & stepMask));  // R6

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic [COL_W-1:0] startCol,
  input  logic             termStb,
  input  logic [2:0]       lenSel,
  input  logic             intlvSel,
  output logic [COL_W-1:0] colOut,
  output logic             beatValid,
  output logic             lastBeat
);

  colStrobe_t       strb;
  logic [COL_W-1:0] stepMask;
  logic [COL_W-1:0] beatNext;

  sdram_colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startStb  (startStb),
    .termStb   (termStb),
    .lenSel    (lenSel),
    .intlvSel  (intlvSel),
    .strb      (strb),
    .stepMask  (stepMask),
    .beatNext  (beatNext),
    .beatValid (beatValid),
    .lastBeat  (lastBeat)
  );

  sdram_colgen_dp #(.COL_W(COL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .stepMask (stepMask),
    .beatNext (beatNext),
    .startCol (startCol),
    .colOut   (colOut)
  );

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !beatValid |-> colOut == '0 && !lastBeat);  // R1

  AST_START_VALID: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> beatValid);  // R10

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat && !startStb |=> !beatValid);  // R4

  AST_TERM_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    termStb && !startStb |=> !beatValid);  // R9

endmodule

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startStb = 1'b0;
  logic [7:0] startCol = '0;
  logic       termStb = 1'b0;
  logic [2:0] lenSel = '0;
  logic       intlvSel = 1'b0;
  logic [7:0] colOut;
  logic       beatValid;
  logic       lastBeat;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  bit         mAct = 0;
  int         mN = 0;
  logic [7:0] mStart = '0;
  logic [2:0] mLen = '0;
  bit         mIl = 0;

  sdram_burst_colgen u_dut (
    .clk(clk), .rstN(rstN), .startStb(startStb), .startCol(startCol),
    .termStb(termStb), .lenSel(lenSel), .intlvSel(intlvSel),
    .colOut(colOut), .beatValid(beatValid), .lastBeat(lastBeat)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int benchLen(input logic [2:0] ln, input bit il);
    case (ln)
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return il ? 8 : 256;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] expCol(input logic [7:0] s, input int n,
                                        input logic [2:0] ln, input bit il);
    logic [7:0] m;
    logic [7:0] nn;
    m  = 8'(benchLen(ln, il) - 1);
    nn = 8'(n);
    if (il) return s ^ (nn & m);
    return (s & ~m) | ((s + nn) & m);
  endfunction

  function automatic bit isPage(input logic [2:0] ln, input bit il);
    return (ln == 3'b111) && !il;
  endfunction

  function automatic string autoTag();
    if (!mAct) return "R9";
    if (mN == 0) return "R2";
    if (isPage(mLen, mIl)) return "R7";
    if (mIl && mLen == 3'b111) return "R8";
    if (mIl) return "R6";
    return "R5";
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    string t;
    bit eLast;
    logic [7:0] eCol;
    t = (tag != "") ? tag : autoTag();
    eLast = mAct && !isPage(mLen, mIl) && (mN == benchLen(mLen, mIl) - 1);
    eCol  = mAct ? expCol(mStart, mN, mLen, mIl) : 8'h00;
    chk(t, "beatValid", int'(beatValid), int'(mAct));
    chk(eLast ? "R4" : t, "lastBeat", int'(lastBeat), int'(eLast));
    chk(t, "colOut", int'(colOut), int'(eCol));
  endtask

  task automatic modelStep(input bit st, input bit tm, input logic [7:0] sc,
                           input logic [2:0] ln, input bit il);
    if (st) begin
      mAct = 1; mN = 0; mStart = sc; mLen = ln; mIl = il;
    end else if (tm) begin
      mAct = 0;
    end else if (mAct) begin
      if (!isPage(mLen, mIl) && mN == benchLen(mLen, mIl) - 1) mAct = 0;
      else mN++;
    end
  endtask

  task automatic tick(input bit st, input bit tm, input logic [7:0] sc,
                      input logic [2:0] ln, input bit il, input string tag);
    startStb = st; termStb = tm; startCol = sc; lenSel = ln; intlvSel = il;
    @(posedge clk);
    modelStep(st, tm, sc, ln, il);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(0, 0, 8'h00, 3'b000, 0, tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'hC01D));
    // R1: reset state
    repeat (3) @(negedge clk);
    compare("R1");
    rstN = 1'b1;
    @(negedge clk);
    compare("R1");

    // R3: every length code, sequential, from a mid-block column
    for (int c = 0; c < 8; c++) begin
      tick(1, 0, 8'hA5, 3'(c), 0, "R3");
      idle(9, "R3");
    end
    // R5: sequential wrap inside an aligned 8-block
    tick(1, 0, 8'h6E, 3'b011, 0, "R5");
    idle(9, "R5");
    // R6: interleave, lengths 2, 4, 8
    tick(1, 0, 8'h3D, 3'b011, 1, "R6");
    idle(9, "R6");
    tick(1, 0, 8'h92, 3'b010, 1, "R6");
    idle(5, "R6");
    tick(1, 0, 8'h01, 3'b001, 1, "R6");
    idle(3, "R6");
    // R8: interleave with the page code acts as 8
    tick(1, 0, 8'hC6, 3'b111, 1, "R8");
    idle(10, "R8");
    // R7: full page wraps past 255 and runs until terminated
    tick(1, 0, 8'hFD, 3'b111, 0, "R7");
    idle(300, "R7");
    tick(0, 1, 8'h00, 3'b000, 0, "R9");
    idle(3, "R9");
    // R9: terminate while idle has no effect
    tick(0, 1, 8'h55, 3'b011, 0, "R9");
    idle(2, "R9");
    // R9: terminate mid-burst
    tick(1, 0, 8'h10, 3'b011, 0, "R9");
    idle(2, "R9");
    tick(0, 1, 8'h00, 3'b000, 0, "R9");
    idle(2, "R9");
    // R10: start and terminate together, start wins
    tick(1, 0, 8'h20, 3'b011, 0, "R10");
    idle(1, "R10");
    tick(1, 1, 8'h47, 3'b010, 1, "R10");
    idle(5, "R10");
    // R10: mode inputs changed mid-burst are ignored
    tick(1, 0, 8'h80, 3'b011, 0, "R10");
    tick(0, 0, 8'hFF, 3'b111, 1, "R10");
    tick(0, 0, 8'h33, 3'b001, 1, "R10");
    idle(7, "R10");
    // R4 / R10: restart on the last beat
    tick(1, 0, 8'h0C, 3'b010, 0, "R4");
    idle(3, "R4");
    tick(1, 0, 8'h71, 3'b001, 0, "R10");
    idle(3, "R4");

    // seeded random mix
    for (int i = 0; i < 4000; i++) begin
      bit st;
      bit tm;
      st = ($urandom % 6) == 0;
      tm = ($urandom % 25) == 0;
      tick(st, tm, 8'($urandom), 3'($urandom), 1'($urandom), "");
    end
    summary();
  end

endmodule